// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block drives an 8-bit NAND-style flash bus from a short program that software loads in advance. It has no built-in read, program or erase flow. The whole transaction is described by an instruction word that holds eight 4-bit micro-operations. The block also takes a command word with four command bytes, a block number, a page index, a column index, a user address byte, a transfer byte count and a 16-bit data register value.

A start pulse launches a run. The block then steps through the slots in order. For each slot it raises the command-latch, address-latch, write or read strobe, emits the matching byte, and waits on the device ready line where the opcode asks for it. Bulk data moves between the device and a byte-wide buffer port. Short one- or two-byte transfers use the data register instead.

When the run ends, a done flag is raised. An overlong ready wait ends the run early and also raises an error flag.

Top module: `fseq_top`

## Requirements
- R1: After reset, busy, done and timeout_err are 0 and all four strobes (fl_cle, fl_ale, fl_we, fl_re) are 0.
- R2: Slot k of instr_word sits in bits [31-4k:28-4k], so slot 0 occupies bits 31:28 and slot 7 occupies bits 3:0. Slots execute in the order 0 to 7, and a run whose eight slots are all active ends after slot 7.
- R3: Opcode 0x0 or 0xF ends the run at that slot without any bus cycle. At that point done becomes 1 and busy becomes 0, and done is never 1 while busy is 1.
- R4: Opcodes 0x4, 0x5, 0x6 and 0x7 each issue one command cycle, with fl_cle and fl_we high. The byte is taken from cmd_word bits 31:24, 23:16, 15:8 or 7:0 respectively.
- R5: Opcode 0x1 issues two address cycles, with fl_ale and fl_we high. The first carries col_idx[7:0] and the second carries {5'b0, col_idx[10:8]}.
- R6: Opcode 0x2 issues three address cycles carrying the row value {blk_num, page_idx}, least significant byte first. Opcode 0x3 issues one address cycle carrying user_addr.
- R7: Opcode 0x8 issues byte_cnt write cycles (fl_we high alone). Cycle i carries buf_rdata while buf_addr = i. If byte_cnt = 0, the slot issues no cycle.
- R8: Opcode 0xA issues byte_cnt read cycles (fl_re high alone). The byte on fl_din during the last strobe clock of cycle i is written to buffer address i, with buf_we pulsed only while fl_re is high.
- R9: Opcode 0x9 writes reg_wdata[7:0] and then, if xfer_two = 1, also reg_wdata[15:8]. Opcode 0xB reads one byte into reg_rdata[7:0] and then, if xfer_two = 1, a second byte into reg_rdata[15:8].
- R10: Opcodes 0xC, 0xD and 0xE raise no strobe while fl_ready is 0. Once fl_ready is 1, they issue the CMD0 command, the CMD1 command or a byte_cnt buffer read respectively.
- R11: If fl_ready stays 0 for rdy_limit+1 consecutive wait clocks, the run ends with timeout_err = 1 and done = 1, and no later slot executes.
- R12: Every strobe stays high for exactly max(pulse_w, 1) clocks. Each strobe is followed by at least one clock with all strobes low, and the strobe pattern never changes while it is high.
- R13: A start pulse while idle makes busy 1 and clears done and timeout_err on the next clock. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| instr_word | input | 32 | Eight 4-bit micro-operation slots |
| cmd_word | input | 32 | Four command bytes |
| blk_num | input | BLK_W | Block number |
| page_idx | input | PAGE_W | Page index within the block |
| col_idx | input | COL_W | Column index |
| user_addr | input | 8 | User-defined address byte |
| byte_cnt | input | CNT_W | Byte count for buffer transfers |
| xfer_two | input | 1 | Short transfers move two bytes when 1 |
| reg_wdata | input | 16 | Data register source for short writes |
| reg_rdata | output | 16 | Data register filled by short reads |
| pulse_w | input | PW_W | Strobe width in clocks (0 acts as 1) |
| rdy_limit | input | TMO_W | Ready-wait timeout limit |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we | output | 1 | Write strobe (active high) |
| fl_re | output | 1 | Read strobe (active high) |
| fl_dout | output | 8 | Byte driven to the device |
| fl_din | input | 8 | Byte from the device |
| fl_ready | input | 1 | Device ready indication |
| buf_addr | output | CNT_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer write data |
| buf_we | output | 1 | Buffer write enable |
| buf_rdata | input | 8 | Buffer read data for buf_addr, same cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has ended |
| timeout_err | output | 1 | Last run ended on a ready timeout |

## Verification
The bench uses the default parameters. BLK_W = 18 gives a 24-bit row value, so row addressing takes exactly three cycles. PW_W = 3 lets the bench try strobe widths of 0, 1, 2, 3 and 4. TMO_W = 8 keeps the timeout short, so rdy_limit = 4 reaches expiry in a few clocks while rdy_limit = 200 lets a long ready delay pass. The 12-bit byte count is tried at 0, 2, 5 and 6, which covers the empty-transfer case without long runs.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int SLOTS   = 8;
    localparam int OP_W    = 4;
    localparam int INSTR_W = SLOTS * OP_W;

    typedef enum logic [3:0] {
        OC_END, OC_CMD, OC_COL, OC_ROW, OC_USER,
        OC_WBUF, OC_WREG, OC_RBUF, OC_RREG
    } op_cls_e;

    typedef struct packed {
        op_cls_e    cls;
        logic       need_rdy;
        logic [1:0] cmd_sel;
    } op_info_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_SETUP, ST_STROBE, ST_GAP
    } seq_state_e;

    function automatic op_info_t decode_op(input logic [OP_W-1:0] code);
        op_info_t r;
        r.cls      = OC_END;
        r.need_rdy = 1'b0;
        r.cmd_sel  = code[1:0];
        case (code)
            4'h1: r.cls = OC_COL;
            4'h2: r.cls = OC_ROW;
            4'h3: r.cls = OC_USER;
            4'h4, 4'h5, 4'h6, 4'h7: r.cls = OC_CMD;
            4'h8: r.cls = OC_WBUF;
            4'h9: r.cls = OC_WREG;
            4'hA: r.cls = OC_RBUF;
            4'hB: r.cls = OC_RREG;
            4'hC, 4'hD: begin r.cls = OC_CMD;  r.need_rdy = 1'b1; end
            4'hE:       begin r.cls = OC_RBUF; r.need_rdy = 1'b1; end
            default: r.cls = OC_END;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fseq_pulse_timer.sv
module fseq_pulse_timer #(
    parameter int PW_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic [PW_W-1:0] width,
    output logic            last
);
    logic [PW_W-1:0] cnt;
    logic [PW_W-1:0] width_eff;

    assign width_eff = (width == '0) ? PW_W'(1) : width;
    assign last      = active && (cnt == width_eff - PW_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !active || last) cnt <= '0;
        else                        cnt <= cnt + PW_W'(1);
    end

    // R12: strobe is not released before its width has elapsed
    assert_pulse_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> active);

endmodule

// File: rtl/fseq_ready_watch.sv
module fseq_ready_watch #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             ready,
    input  logic [TMO_W-1:0] limit,
    output logic             go,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    assign go      = active && ready;
    assign expired = active && !ready && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !active || ready) cnt <= '0;
        else if (!expired)           cnt <= cnt + TMO_W'(1);
    end

    // R11: the wait counter never passes the limit
    assert_wait_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (active && !ready) |-> (cnt <= limit));

endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int BLK_W  = 18,
    parameter int PAGE_W = 6,
    parameter int COL_W  = 11,
    parameter int CNT_W  = 12,
    parameter int PW_W   = 3,
    parameter int TMO_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [31:0]        instr_word,
    input  logic [31:0]        cmd_word,
    input  logic [BLK_W-1:0]   blk_num,
    input  logic [PAGE_W-1:0]  page_idx,
    input  logic [COL_W-1:0]   col_idx,
    input  logic [7:0]         user_addr,
    input  logic [CNT_W-1:0]   byte_cnt,
    input  logic               xfer_two,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    input  logic [PW_W-1:0]    pulse_w,
    input  logic [TMO_W-1:0]   rdy_limit,
    output logic               fl_cle,
    output logic               fl_ale,
    output logic               fl_we,
    output logic               fl_re,
    output logic [7:0]         fl_dout,
    input  logic [7:0]         fl_din,
    input  logic               fl_ready,
    output logic [CNT_W-1:0]   buf_addr,
    output logic [7:0]         buf_wdata,
    output logic               buf_we,
    input  logic [7:0]         buf_rdata,
    output logic               busy,
    output logic               done,
    output logic               timeout_err
);
    localparam int ROW_W     = BLK_W + PAGE_W;
    localparam int ROW_BYTES = (ROW_W + 7) / 8;
    localparam int COL_BYTES = (COL_W + 7) / 8;
    localparam logic [2:0] LAST_SLOT = 3'(SLOTS - 1);

    seq_state_e        state;
    logic [2:0]        slot;
    op_info_t          cur;
    op_info_t          fetched;
    logic [OP_W-1:0]   code;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  n_items;
    logic [15:0]       rreg;
    logic              strobe_on, p_last, rdy_go, tmo_exp;
    logic [7:0]        row_byte, col_byte, cmd_byte, data_byte;
    logic [ROW_BYTES*8-1:0] row_pad;
    logic [COL_BYTES*8-1:0] col_pad;

    // slot fetch and decode
    always_comb begin
        code = '0;
        for (int k = 0; k < SLOTS; k++)
            if (slot == 3'(k)) code = instr_word[(SLOTS-1-k)*OP_W +: OP_W];
    end
    assign fetched = decode_op(code);

    // item count of the current operation
    always_comb begin
        case (cur.cls)
            OC_CMD, OC_USER:  n_items = CNT_W'(1);
            OC_COL:           n_items = CNT_W'(COL_BYTES);
            OC_ROW:           n_items = CNT_W'(ROW_BYTES);
            OC_WBUF, OC_RBUF: n_items = byte_cnt;
            OC_WREG, OC_RREG: n_items = xfer_two ? CNT_W'(2) : CNT_W'(1);
            default:          n_items = '0;
        endcase
    end

    // outgoing byte selection
    assign row_pad = (ROW_BYTES*8)'({blk_num, page_idx});
    assign col_pad = (COL_BYTES*8)'(col_idx);

    always_comb begin
        row_byte = '0;
        for (int k = 0; k < ROW_BYTES; k++)
            if (idx == CNT_W'(k)) row_byte = row_pad[k*8 +: 8];
        col_byte = '0;
        for (int k = 0; k < COL_BYTES; k++)
            if (idx == CNT_W'(k)) col_byte = col_pad[k*8 +: 8];
        case (cur.cmd_sel)
            2'd0:    cmd_byte = cmd_word[31:24];
            2'd1:    cmd_byte = cmd_word[23:16];
            2'd2:    cmd_byte = cmd_word[15:8];
            default: cmd_byte = cmd_word[7:0];
        endcase
        case (cur.cls)
            OC_CMD:  data_byte = cmd_byte;
            OC_COL:  data_byte = col_byte;
            OC_ROW:  data_byte = row_byte;
            OC_USER: data_byte = user_addr;
            OC_WBUF: data_byte = buf_rdata;
            OC_WREG: data_byte = idx[0] ? reg_wdata[15:8] : reg_wdata[7:0];
            default: data_byte = 8'h00;
        endcase
    end

    assign strobe_on = (state == ST_STROBE);
    assign fl_cle    = strobe_on && (cur.cls == OC_CMD);
    assign fl_ale    = strobe_on && (cur.cls inside {OC_COL, OC_ROW, OC_USER});
    assign fl_re     = strobe_on && (cur.cls inside {OC_RBUF, OC_RREG});
    assign fl_we     = strobe_on && !(cur.cls inside {OC_RBUF, OC_RREG});
    assign fl_dout   = strobe_on ? data_byte : 8'h00;
    assign buf_addr  = idx;
    assign buf_wdata = fl_din;
    assign buf_we    = strobe_on && p_last && (cur.cls == OC_RBUF);
    assign reg_rdata = rreg;
    assign busy      = (state != ST_IDLE);

    fseq_pulse_timer #(.PW_W(PW_W)) u_timer (
        .clk(clk), .rst(rst), .active(strobe_on), .width(pulse_w), .last(p_last)
    );

    fseq_ready_watch #(.TMO_W(TMO_W)) u_rdy (
        .clk(clk), .rst(rst), .active(state == ST_WAIT), .ready(fl_ready),
        .limit(rdy_limit), .go(rdy_go), .expired(tmo_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            slot        <= '0;
            cur         <= '{cls: OC_END, need_rdy: 1'b0, cmd_sel: 2'b00};
            idx         <= '0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            rreg        <= '0;
        end else begin
            if (strobe_on && p_last && cur.cls == OC_RREG) begin
                if (idx[0]) rreg[15:8] <= fl_din;
                else        rreg[7:0]  <= fl_din;
            end
            case (state)
                ST_IDLE: if (start) begin
                    state       <= ST_FETCH;
                    slot        <= '0;
                    done        <= 1'b0;
                    timeout_err <= 1'b0;
                end
                ST_FETCH: if (fetched.cls == OC_END) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    cur   <= fetched;
                    state <= fetched.need_rdy ? ST_WAIT : ST_SETUP;
                end
                ST_WAIT: if (rdy_go) begin
                    state <= ST_SETUP;
                end else if (tmo_exp) begin
                    state       <= ST_IDLE;
                    done        <= 1'b1;
                    timeout_err <= 1'b1;
                end
                ST_SETUP: begin
                    idx <= '0;
                    if (n_items != '0)            state <= ST_STROBE;
                    else if (slot == LAST_SLOT) begin state <= ST_IDLE; done <= 1'b1; end
                    else begin slot <= slot + 3'd1; state <= ST_FETCH; end
                end
                ST_STROBE: if (p_last) state <= ST_GAP;
                ST_GAP: begin
                    if (idx + CNT_W'(1) != n_items) begin
                        idx   <= idx + CNT_W'(1);
                        state <= ST_STROBE;
                    end else if (slot == LAST_SLOT) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        slot  <= slot + 3'd1;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R13: an accepted start begins a fresh run
    assert_start_busy_R13: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done && !timeout_err));

    // R11: an expired wait ends the run with the error flag
    assert_timeout_end_R11: assert property (@(posedge clk) disable iff (rst)
        tmo_exp |=> (timeout_err && done && !busy));

    // R8: buffer writes happen only under the read strobe
    assert_bufwe_read_R8: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (fl_re && !fl_we));

    // R3: done and busy are never both high
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/tb_fseq_top.sv
module tb_fseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr_word = '0, cmd_word = 32'hA1B2C3D4;
    logic [17:0] blk_num = 18'h12345;
    logic [5:0]  page_idx = 6'h2A;
    logic [10:0] col_idx = 11'h5A7;
    logic [7:0]  user_addr = 8'h9E;
    logic [11:0] byte_cnt = '0;
    logic        xfer_two = 1'b0;
    logic [15:0] reg_wdata = 16'hBEEF, reg_rdata;
    logic [2:0]  pulse_w = 3'd1;
    logic [7:0]  rdy_limit = 8'd200;
    logic        fl_cle, fl_ale, fl_we, fl_re, fl_ready = 1'b1;
    logic [7:0]  fl_dout, fl_din, buf_wdata, buf_rdata;
    logic [11:0] buf_addr;
    logic        buf_we, busy, done, timeout_err;

    localparam logic [3:0] K_CMD = 4'b1010, K_ADR = 4'b0110, K_WR = 4'b0010, K_RD = 4'b0001;

    int checks = 0, fails = 0, rd_seen = 0, exp_w = 1;
    bit rd_guard = 1'b0, ended = 1'b0;
    logic [11:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  rbuf [0:63];

    always #10 clk = ~clk;

    assign fl_din    = 8'h3C + 8'(rd_seen * 5);
    assign buf_rdata = 8'h11 + buf_addr[7:0] * 8'd7;
    always @(posedge clk) if (buf_we) rbuf[buf_addr[5:0]] <= buf_wdata;

    fseq_top dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] k, input logic [7:0] b, input string tag);
        exp_q.push_back({k, b});
        tag_q.push_back(tag);
    endtask

    // monitor: compare every completed strobe against the scoreboard
    logic [3:0] prev_s = '0, ev_k;
    logic [7:0] ev_b;
    int ev_w;
    always @(negedge clk) begin
        logic [3:0]  s;
        logic [11:0] e;
        string       t;
        s = {fl_cle, fl_ale, fl_we, fl_re};
        if (!rst) begin
            if (s != 4'b0 && rd_guard) chk(1'b0, "R10 strobe while not ready", 32'(s), 32'h0);
            if (s != 4'b0) begin
                if (prev_s == 4'b0) begin ev_k = s; ev_b = fl_dout; ev_w = 1; end
                else begin
                    ev_w++;
                    if (s != prev_s) chk(1'b0, "R12 pattern changed", 32'(s), 32'(prev_s));
                end
            end else if (prev_s != 4'b0) begin
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected cycle", {20'h0, ev_k, ev_b}, 32'h0);
                else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(ev_k == e[11:8] && (e[11:8] == K_RD || ev_b == e[7:0]), t,
                        {20'h0, ev_k, ev_b}, {20'h0, e});
                    chk(ev_w == exp_w, "R12 strobe width", 32'(ev_w), 32'(exp_w));
                end
                if (prev_s == K_RD) rd_seen++;
            end
        end
        prev_s = s;
    end

    task automatic launch(input logic [31:0] iw);
        @(negedge clk);
        instr_word = iw;
        exp_w = (pulse_w == 3'd0) ? 1 : int'(pulse_w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !timeout_err, "R13 start accepted", {29'h0, busy, done, timeout_err}, 32'h4);
    endtask

    task automatic finish_run(input string tag);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        chk(done && !busy, tag, {30'h0, done, busy}, 32'h2);
        chk(exp_q.size() == 0, "R2 all expected cycles seen", 32'(exp_q.size()), 32'h0);
    endtask

    logic [23:0] row;

    initial begin
        int base;
        row = {blk_num, page_idx};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !timeout_err && {fl_cle, fl_ale, fl_we, fl_re} == 4'b0,
            "R1 reset state", {26'h0, busy, done, timeout_err, fl_cle, fl_ale, fl_we}, 32'h0);

        // command, column, row, user address, CMD2, CMD3
        pulse_w = 3'd2;
        push(K_CMD, cmd_word[31:24], "R4 CMD0");
        push(K_ADR, col_idx[7:0], "R5 column low");
        push(K_ADR, {5'b0, col_idx[10:8]}, "R5 column high");
        push(K_ADR, row[7:0], "R6 row byte0");
        push(K_ADR, row[15:8], "R6 row byte1");
        push(K_ADR, row[23:16], "R6 row byte2");
        push(K_ADR, user_addr, "R6 user address");
        push(K_CMD, cmd_word[15:8], "R4 CMD2");
        push(K_CMD, cmd_word[7:0], "R4 CMD3");
        launch(32'h4123_6700);
        finish_run("R3 end at opcode 0");

        // all eight slots active, width 0 acts as 1
        pulse_w = 3'd0;
        for (int r = 0; r < 2; r++) begin
            push(K_CMD, cmd_word[31:24], "R2 slot order CMD0");
            push(K_CMD, cmd_word[23:16], "R2 slot order CMD1");
            push(K_CMD, cmd_word[15:8], "R2 slot order CMD2");
            push(K_CMD, cmd_word[7:0], "R2 slot order CMD3");
        end
        launch(32'h4567_4567);
        finish_run("R2 end after slot 7");

        // buffer write of five bytes
        pulse_w = 3'd3;
        byte_cnt = 12'd5;
        push(K_CMD, cmd_word[31:24], "R4 CMD0");
        for (int i = 0; i < 5; i++) push(K_WR, 8'h11 + 8'(i) * 8'd7, "R7 buffer write");
        push(K_CMD, cmd_word[23:16], "R4 CMD1");
        launch(32'h4850_0000);
        finish_run("R7 write run");

        // zero byte count
        byte_cnt = 12'd0;
        push(K_CMD, cmd_word[31:24], "R7 zero count before");
        push(K_CMD, cmd_word[31:24], "R7 zero count after");
        launch(32'h4840_0000);
        finish_run("R7 zero count run");

        // buffer read of six bytes
        pulse_w = 3'd1;
        byte_cnt = 12'd6;
        base = rd_seen;
        for (int i = 0; i < 6; i++) push(K_RD, 8'h00, "R8 buffer read");
        launch(32'hA000_0000);
        finish_run("R8 read run");
        for (int i = 0; i < 6; i++)
            chk(rbuf[i] == 8'h3C + 8'((base + i) * 5), "R8 buffer content", 32'(rbuf[i]), 32'(8'h3C + 8'((base + i) * 5)));

        // two-byte register write and read
        xfer_two = 1'b1;
        push(K_WR, reg_wdata[7:0], "R9 reg write low");
        push(K_WR, reg_wdata[15:8], "R9 reg write high");
        push(K_RD, 8'h00, "R9 reg read low");
        push(K_RD, 8'h00, "R9 reg read high");
        base = rd_seen;
        launch(32'h9B00_0000);
        finish_run("R9 two byte run");
        chk(reg_rdata == {8'h3C + 8'((base + 1) * 5), 8'h3C + 8'(base * 5)}, "R9 reg read value",
            32'(reg_rdata), 32'({8'h3C + 8'((base + 1) * 5), 8'h3C + 8'(base * 5)}));
        xfer_two = 1'b0;
        push(K_WR, reg_wdata[7:0], "R9 one byte write");
        launch(32'h9000_0000);
        finish_run("R9 one byte run");

        // ready waits
        pulse_w = 3'd2;
        byte_cnt = 12'd2;
        fl_ready = 1'b0;
        rd_guard = 1'b1;
        push(K_CMD, cmd_word[31:24], "R10 wait then CMD0");
        push(K_CMD, cmd_word[23:16], "R10 wait then CMD1");
        push(K_RD, 8'h00, "R10 wait then read");
        push(K_RD, 8'h00, "R10 wait then read");
        launch(32'hCDE0_0000);
        repeat (10) @(negedge clk);
        chk(busy && !done, "R10 held while not ready", {30'h0, busy, done}, 32'h2);
        rd_guard = 1'b0;
        fl_ready = 1'b1;
        finish_run("R10 wait run");

        // timeout
        rdy_limit = 8'd4;
        fl_ready = 1'b0;
        push(K_CMD, cmd_word[31:24], "R11 cycle before wait");
        launch(32'h4C40_0000);
        finish_run("R11 timeout ends run");
        chk(timeout_err == 1'b1, "R11 timeout flag", 32'(timeout_err), 32'h1);
        fl_ready = 1'b1;
        rdy_limit = 8'd200;

        // 0xF ends immediately, start clears the error
        launch(32'hF400_0000);
        finish_run("R3 opcode F ends");
        chk(timeout_err == 1'b0, "R13 error cleared by start", 32'(timeout_err), 32'h0);

        // start while busy is ignored
        pulse_w = 3'd4;
        for (int r = 0; r < 2; r++) begin
            push(K_CMD, cmd_word[31:24], "R13 busy start CMD0");
            push(K_CMD, cmd_word[23:16], "R13 busy start CMD1");
            push(K_CMD, cmd_word[15:8], "R13 busy start CMD2");
            push(K_CMD, cmd_word[7:0], "R13 busy start CMD3");
        end
        launch(32'h4567_4567);
        repeat (12) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run("R13 run not restarted");
        repeat (5) @(negedge clk);
        chk(!busy, "R13 no second run", 32'(busy), 32'h0);

        ended = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule